// File: doc/BRIEF.md
# Sequential Port Address Pointer with End-of-Buffer Flags

This block drives the clocked side of a dual-port 4096 x 16 buffer. It keeps a 12-bit pointer that selects the array word for the clocked port. On each rising clock edge the pointer can advance by one. It can also jump to one of two programmable buffer start addresses, or take a value that was captured from the data bus one cycle earlier. Every pointer change is decided by control inputs sampled on the rising edge.

Two end-of-buffer registers are compared against the pointer each time it advances. When an increment lands exactly on a buffer's end address, that buffer's active-low flag drops and stays low until it is explicitly cleared. A small configuration write port programs the start and end addresses and carries the flag-clear control word.

The block also registers the access request on every edge. It gives the array a write strobe, a read strobe, the address that was current when the request was sampled, and the captured write data.

Top module: `seq_ptr_flags`

## Requirements
- R1: While `rst_n` is low, asynchronously and without waiting for a clock edge, `ptr` is 0, both flags are high, both strobes are low, and the start and end registers hold 0.
- R2: On a rising edge with `cnt_n` low and no higher-priority action, `ptr` becomes `ptr+1` modulo 4096, whatever the value of `cen_n`. With `cnt_n` high and no other action, `ptr` holds.
- R3: When `ld_n` is sampled low, `sdin[11:0]` is captured. `ptr` takes that value at the following rising edge, not at the same one. At that following edge the pending load overrides any jump or count. A start strobe must not be low in the load cycle or in the cycle after it.
- R4: `jmp1_n` sampled low loads `ptr` from start register 1. It wins over `jmp2_n` and over `cnt_n`.
- R5: `jmp2_n` sampled low, with `jmp1_n` high, loads `ptr` from start register 2. It wins over `cnt_n`.
- R6: The configuration port writes on a rising edge with `cfg_we` high. `cfg_sel` 0 selects start 1, 1 selects end 1, 2 selects start 2, 3 selects end 2, and 5 selects the control word.
- R7: A flag (`eob1_n` for buffer 1, `eob2_n` for buffer 2) goes low at the edge where an increment makes `ptr` equal to that buffer's end register. Reaching the same value by a jump or a load leaves the flag unchanged.
- R8: A low flag stays low while the pointer moves on, until it is cleared. If the flag is set and cleared at the same edge, the set wins.
- R9: A control-word write clears flag 1 when bit 0 is 0 and clears flag 2 when bit 1 is 0. A bit that is 1 leaves its flag unchanged.
- R10: `wr_stb` is high for the cycle after an edge that sampled `cen_n` low and `rw` low. `acc_wdata` then holds the `sdin` sampled at that edge.
- R11: `rd_stb` is high for the cycle after an edge that sampled `cen_n` low, `rw` high and `oen_n` low. Otherwise it is low.
- R12: `acc_addr` holds the `ptr` value that was current when the access was sampled, that is, the value from before that edge's pointer update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cen_n | input | 1 | Port enable, active low |
| rw | input | 1 | 1 = read, 0 = write |
| oen_n | input | 1 | Output enable, active low, qualifies reads |
| cnt_n | input | 1 | Count enable, active low |
| ld_n | input | 1 | Pointer load from data bus, active low |
| jmp1_n | input | 1 | Jump to start address 1, active low |
| jmp2_n | input | 1 | Jump to start address 2, active low |
| sdin | input | 16 | Clocked-port write data; bits 11:0 are the load value |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 12 | Configuration write data |
| ptr | output | 12 | Current pointer |
| acc_addr | output | 12 | Address of the registered access |
| acc_wdata | output | 16 | Registered write data |
| wr_stb | output | 1 | Registered write strobe |
| rd_stb | output | 1 | Registered read strobe |
| eob1_n | output | 1 | End-of-buffer flag 1, active low |
| eob2_n | output | 1 | End-of-buffer flag 2, active low |

## Verification
The bench counts through all 4096 pointer values with the port disabled. This exposes a counter that stalls on chip enable or that fails to wrap, and it shows whether a flag trips at the default end address only on the wrapping increment. A load issued together with counting shows whether the design applies the load a cycle early, or lets the count win in the cycle after the load. Jumps directly onto an end address and simultaneous set and clear writes target flag logic that compares on any pointer change or lets a clear swallow a new match. All eight enable and direction combinations check strobe decoding, and a run of reads while counting checks that the access address is not taken after the update.

// File: rtl/seqp_pkg.sv
package seqp_pkg;
    localparam int NBUF = 2;

    typedef enum logic [2:0] {
        SEL_START1 = 3'd0,
        SEL_END1   = 3'd1,
        SEL_START2 = 3'd2,
        SEL_END2   = 3'd3,
        SEL_CTRL   = 3'd5
    } cfg_sel_e;
endpackage

// File: rtl/seqp_cfg_regs.sv
module seqp_cfg_regs
    import seqp_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_sel,
    input  logic [AW-1:0]            cfg_wdata,
    output logic [NBUF-1:0][AW-1:0]  start_addr,
    output logic [NBUF-1:0][AW-1:0]  end_addr,
    output logic [NBUF-1:0]          flag_clr
);
    typedef struct packed {
        logic [NBUF-1:0][AW-1:0] st;
        logic [NBUF-1:0][AW-1:0] en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d    = cfg_q;
        flag_clr = '0;
        if (cfg_we) begin
            for (int k = 0; k < NBUF; k++) begin
                if (cfg_sel == 3'(2 * k))     cfg_d.st[k] = cfg_wdata;
                if (cfg_sel == 3'(2 * k + 1)) cfg_d.en[k] = cfg_wdata;
                if (cfg_sel == SEL_CTRL)      flag_clr[k] = !cfg_wdata[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign start_addr = cfg_q.st;
    assign end_addr   = cfg_q.en;
endmodule

// File: rtl/seqp_pointer.sv
module seqp_pointer
    import seqp_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cnt_n,
    input  logic                     ld_n,
    input  logic [NBUF-1:0]          jmp_n,
    input  logic [AW-1:0]            ld_val,
    input  logic [NBUF-1:0][AW-1:0]  start_addr,
    output logic [AW-1:0]            ptr,
    output logic                     ld_pend,
    output logic                     inc_go,
    output logic [AW-1:0]            inc_val
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [AW-1:0] dreg;
        logic          pend;
    } pst_t;

    pst_t p_d, p_q;
    logic          jump_hit;
    logic [AW-1:0] jump_val;

    // lowest-numbered asserted strobe wins: scan down, last match kept
    always_comb begin
        jump_hit = 1'b0;
        jump_val = '0;
        for (int k = NBUF - 1; k >= 0; k--) begin
            if (!jmp_n[k]) begin
                jump_hit = 1'b1;
                jump_val = start_addr[k];
            end
        end
    end

    always_comb begin
        p_d      = p_q;
        p_d.pend = !ld_n;
        if (!ld_n) p_d.dreg = ld_val;
        inc_val  = p_q.ptr + 1'b1;
        inc_go   = 1'b0;
        if (p_q.pend) begin
            p_d.ptr = p_q.dreg;
        end else if (jump_hit) begin
            p_d.ptr = jump_val;
        end else if (!cnt_n) begin
            p_d.ptr = inc_val;
            inc_go  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign ptr     = p_q.ptr;
    assign ld_pend = p_q.pend;
endmodule

// File: rtl/seqp_eob_flag.sv
module seqp_eob_flag #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_go,
    input  logic [AW-1:0] inc_val,
    input  logic [AW-1:0] end_addr,
    input  logic          clr,
    output logic          flag_n
);
    logic flag_n_d, flag_n_q;
    logic hit;

    always_comb begin
        hit      = inc_go && (inc_val == end_addr);
        flag_n_d = flag_n_q;
        if (hit)      flag_n_d = 1'b0;
        else if (clr) flag_n_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_n_q <= 1'b1;
        else        flag_n_q <= flag_n_d;
    end

    assign flag_n = flag_n_q;
endmodule

// File: rtl/seqp_access.sv
module seqp_access #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cen_n,
    input  logic          rw,
    input  logic          oen_n,
    input  logic [AW-1:0] ptr,
    input  logic [DW-1:0] sdin,
    output logic          wr_stb,
    output logic          rd_stb,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_wdata
);
    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } acc_t;

    acc_t a_d, a_q;

    always_comb begin
        a_d      = a_q;
        a_d.wr   = !cen_n && !rw;
        a_d.rd   = !cen_n && rw && !oen_n;
        a_d.addr = ptr;
        if (a_d.wr) a_d.wdata = sdin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign wr_stb    = a_q.wr;
    assign rd_stb    = a_q.rd;
    assign acc_addr  = a_q.addr;
    assign acc_wdata = a_q.wdata;
endmodule

// File: rtl/seq_ptr_flags.sv
module seq_ptr_flags
    import seqp_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cen_n,
    input  logic          rw,
    input  logic          oen_n,
    input  logic          cnt_n,
    input  logic          ld_n,
    input  logic          jmp1_n,
    input  logic          jmp2_n,
    input  logic [DW-1:0] sdin,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_wdata,
    output logic          wr_stb,
    output logic          rd_stb,
    output logic          eob1_n,
    output logic          eob2_n
);
    logic [NBUF-1:0][AW-1:0] start_addr;
    logic [NBUF-1:0][AW-1:0] end_addr;
    logic [NBUF-1:0]         flag_clr;
    logic [NBUF-1:0]         flag_n;
    logic                    ld_pend;
    logic                    inc_go;
    logic [AW-1:0]           inc_val;

    seqp_cfg_regs #(.AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start_addr(start_addr), .end_addr(end_addr),
        .flag_clr(flag_clr)
    );

    seqp_pointer #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .cnt_n(cnt_n), .ld_n(ld_n),
        .jmp_n({jmp2_n, jmp1_n}), .ld_val(sdin[AW-1:0]),
        .start_addr(start_addr), .ptr(ptr), .ld_pend(ld_pend),
        .inc_go(inc_go), .inc_val(inc_val)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_flag
        seqp_eob_flag #(.AW(AW)) u_flag (
            .clk(clk), .rst_n(rst_n), .inc_go(inc_go), .inc_val(inc_val),
            .end_addr(end_addr[g]), .clr(flag_clr[g]), .flag_n(flag_n[g])
        );
    end

    seqp_access #(.AW(AW), .DW(DW)) u_acc (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .rw(rw), .oen_n(oen_n),
        .ptr(ptr), .sdin(sdin), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata)
    );

    assign eob1_n = flag_n[0];
    assign eob2_n = flag_n[1];
endmodule

// File: rtl/seqp_checker.sv
module seqp_checker #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cen_n,
    input logic                 rw,
    input logic                 oen_n,
    input logic                 cnt_n,
    input logic                 ld_n,
    input logic                 jmp1_n,
    input logic                 jmp2_n,
    input logic [DW-1:0]        sdin,
    input logic                 cfg_we,
    input logic [2:0]           cfg_sel,
    input logic [AW-1:0]        cfg_wdata,
    input logic [AW-1:0]        ptr,
    input logic [AW-1:0]        acc_addr,
    input logic                 wr_stb,
    input logic                 rd_stb,
    input logic                 eob1_n,
    input logic                 eob2_n,
    input logic                 ld_pend,
    input logic [1:0][AW-1:0]   start_addr,
    input logic [1:0][AW-1:0]   end_addr
);
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_n && jmp1_n && jmp2_n && !ld_pend) |=> ptr == AW'($past(ptr) + 1'b1));

    assert_load_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> ##1 (ptr == $past(sdin[AW-1:0], 2)));

    assert_no_jump_near_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !((!jmp1_n || !jmp2_n) && (!ld_n || ld_pend)));

    assert_jump1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!jmp1_n && !ld_pend) |=> ptr == $past(start_addr[0]));

    assert_jump2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!jmp2_n && jmp1_n && !ld_pend) |=> ptr == $past(start_addr[1]));

    assert_flag1_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eob1_n) |-> (ptr == $past(end_addr[0]) && $past(!cnt_n)));

    assert_flag2_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eob2_n) |-> (ptr == $past(end_addr[1]) && $past(!cnt_n)));

    assert_flag1_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!eob1_n && !(cfg_we && cfg_sel == 3'd5 && !cfg_wdata[0])) |=> !eob1_n);

    assert_flag2_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!eob2_n && !(cfg_we && cfg_sel == 3'd5 && !cfg_wdata[1])) |=> !eob2_n);

    assert_write_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !rw) |=> wr_stb);

    assert_write_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cen_n || rw) |=> !wr_stb);

    assert_read_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && rw && !oen_n) |=> rd_stb);

    assert_read_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cen_n || !rw || oen_n) |=> !rd_stb);

    assert_acc_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cen_n |=> acc_addr == $past(ptr));
endmodule

bind seq_ptr_flags seqp_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .rw(rw), .oen_n(oen_n),
    .cnt_n(cnt_n), .ld_n(ld_n), .jmp1_n(jmp1_n), .jmp2_n(jmp2_n),
    .sdin(sdin), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ptr(ptr), .acc_addr(acc_addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .eob1_n(eob1_n), .eob2_n(eob2_n), .ld_pend(ld_pend),
    .start_addr(start_addr), .end_addr(end_addr)
);

// File: tb/sim_seq_ptr_flags.sv
module sim_seq_ptr_flags;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cen_n = 1'b1, rw = 1'b1, oen_n = 1'b1, cnt_n = 1'b1, ld_n = 1'b1;
    logic jmp1_n = 1'b1, jmp2_n = 1'b1, cfg_we = 1'b0;
    logic [DW-1:0] sdin = '0;
    logic [2:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] ptr, acc_addr;
    logic [DW-1:0] acc_wdata;
    logic wr_stb, rd_stb, eob1_n, eob2_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    seq_ptr_flags #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .rw(rw), .oen_n(oen_n),
        .cnt_n(cnt_n), .ld_n(ld_n), .jmp1_n(jmp1_n), .jmp2_n(jmp2_n),
        .sdin(sdin), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ptr(ptr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .eob1_n(eob1_n), .eob2_n(eob2_n)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [AW-1:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [AW-1:0] held;
        repeat (2) @(negedge clk);
        // R1: state while reset is held
        check("R1", "ptr", 32'(ptr), 0);
        check("R1", "flags", {eob2_n, eob1_n}, 2'b11);
        check("R1", "strobes", {wr_stb, rd_stb}, 2'b00);
        rst_n = 1'b1;
        tick();

        // R2: full sweep with the port disabled; default end address 0 trips both flags on wrap (R7)
        cnt_n = 1'b0;
        for (int k = 1; k <= DEPTH; k++) begin
            tick();
            check("R2", "sweep ptr", 32'(ptr), 32'(k % DEPTH));
            check("R7", "sweep flags", {eob2_n, eob1_n}, (k == DEPTH) ? 2'b00 : 2'b11);
        end
        cnt_n = 1'b1;
        tick(); tick();
        check("R2", "hold ptr", 32'(ptr), 0);

        // R9: clear flag 1 only, then flag 2 only (control select 5)
        cfg_write(3'd5, 12'h002);
        check("R9", "clear flag1 only", {eob2_n, eob1_n}, 2'b01);
        cfg_write(3'd5, 12'h001);
        check("R9", "clear flag2 only", {eob2_n, eob1_n}, 2'b11);

        // R6: program start/end registers by select code
        cfg_write(3'd0, 12'h00F);
        cfg_write(3'd1, 12'h010);
        cfg_write(3'd2, 12'h020);
        cfg_write(3'd3, 12'h020);

        // R5 and R7: jump onto end address 2 leaves flag 2 high
        jmp2_n = 1'b0; tick(); jmp2_n = 1'b1;
        check("R5", "jump2 ptr", 32'(ptr), 32'h020);
        check("R7", "jump does not set flag2", 32'(eob2_n), 1);

        // R4: jump1 beats jump2 and count
        jmp1_n = 1'b0; jmp2_n = 1'b0; cnt_n = 1'b0; tick();
        check("R4", "jump1 priority", 32'(ptr), 32'h00F);
        jmp1_n = 1'b1; tick();
        check("R5", "jump2 beats count", 32'(ptr), 32'h020);
        jmp2_n = 1'b1; cnt_n = 1'b1;
        jmp1_n = 1'b0; tick(); jmp1_n = 1'b1;
        check("R4", "jump1 ptr", 32'(ptr), 32'h00F);

        // R7 and R8: increment onto end 1 sets flag, stays low past it
        cnt_n = 1'b0; tick();
        check("R7", "flag1 set by increment", {eob2_n, eob1_n}, 2'b10);
        tick(); tick();
        check("R8", "flag1 sticky", {eob2_n, eob1_n}, 2'b10);
        check("R2", "ptr after count", 32'(ptr), 32'h012);
        cnt_n = 1'b1;
        cfg_write(3'd5, 12'h002);
        check("R9", "flag1 cleared", 32'(eob1_n), 1);

        // R8: set and clear at the same edge, set wins
        jmp1_n = 1'b0; tick(); jmp1_n = 1'b1;
        cnt_n = 1'b0; cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = 12'h002;
        tick();
        cfg_we = 1'b0; cnt_n = 1'b1;
        check("R8", "set wins over clear", 32'(eob1_n), 0);
        cfg_write(3'd5, 12'h000);
        check("R9", "clear both", {eob2_n, eob1_n}, 2'b11);

        // R3: load lands one cycle later
        held = ptr;
        ld_n = 1'b0; sdin = 16'hFABC; tick(); ld_n = 1'b1;
        check("R3", "ptr unchanged in load cycle", 32'(ptr), 32'(held));
        tick();
        check("R3", "ptr loaded", 32'(ptr), 32'hABC);
        ld_n = 1'b0; sdin = 16'h0123; cnt_n = 1'b0; tick(); ld_n = 1'b1;
        check("R3", "count in load cycle", 32'(ptr), 32'hABD);
        tick();
        check("R3", "load beats count", 32'(ptr), 32'h123);
        tick();
        check("R2", "count resumes", 32'(ptr), 32'h124);
        cnt_n = 1'b1;
        ld_n = 1'b0; sdin = 16'h0010; tick(); ld_n = 1'b1; tick();
        check("R3", "load end address", 32'(ptr), 32'h010);
        check("R7", "load does not set flag1", 32'(eob1_n), 1);

        // R10/R11/R12: all enable/direction combinations with pointer held
        for (int c = 0; c < 8; c++) begin
            cen_n = c[0]; rw = c[1]; oen_n = c[2];
            sdin = 16'h5A00 + 16'(c);
            tick();
            check("R10", "write strobe", 32'(wr_stb), 32'(!c[0] && !c[1]));
            check("R11", "read strobe", 32'(rd_stb), 32'(!c[0] && c[1] && !c[2]));
            if (!c[0] && !c[1])
                check("R10", "write data", 32'(acc_wdata), 32'(16'h5A00 + 16'(c)));
            check("R12", "access addr held", 32'(acc_addr), 32'h010);
        end
        // R12: reads while counting carry the pre-update pointer
        cen_n = 1'b0; rw = 1'b1; oen_n = 1'b0; cnt_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R12", "access addr while counting", 32'(acc_addr), 32'(AW'(ptr - 1'b1)));
            check("R11", "read strobe while counting", 32'(rd_stb), 1);
        end
        cen_n = 1'b1; rw = 1'b1; oen_n = 1'b1; cnt_n = 1'b1;
        tick();

        // R1: asynchronous reset mid-cycle with a flag low
        cfg_write(3'd3, AW'(ptr + 1'b1));
        cnt_n = 1'b0; tick(); cnt_n = 1'b1;
        check("R7", "flag2 set before reset", 32'(eob2_n), 0);
        #3 rst_n = 1'b0;
        #2;
        check("R1", "async ptr", 32'(ptr), 0);
        check("R1", "async flags", {eob2_n, eob1_n}, 2'b11);
        @(negedge clk);
        rst_n = 1'b1;
        cnt_n = 1'b0; tick(); cnt_n = 1'b1;
        jmp1_n = 1'b0; tick(); jmp1_n = 1'b1;
        check("R1", "start1 back to default", 32'(ptr), 0);

        finish_run();
    end
endmodule